// File: doc/BRIEF.md
# Input Buffer Request and Overrun Monitor

This block manages the input side of a sample-processing filter. Samples enter a one-word holding slot through a write port. The filter takes a word from the slot with a valid/ready handshake. The block raises a service request in one of two ways, chosen by a mode input. In standalone mode the request is a level that stays high while the slot is empty, so that a CPU or DMA engine writes the next sample. In monitor mode the request is a flag that is set each time a word is handed to the filter. A copy of that word is kept in a readout register so that software or DMA can collect it.

In monitor mode, if the copy is replaced while the previous request is still pending, a sticky overrun flag is raised. A select input steers the request to the interrupt line, where an enable also gates it, or to the DMA request line. A write-one clear, a DMA read acknowledge and a soft reset remove a pending monitor request. The overrun flag has its own clear input.

Top module: `ibuf_req_monitor`

## Requirements
- R1: In standalone mode (`mode_dbg`=0) the request is high while the slot is empty. It drops in the cycle after a write is accepted into the slot, and it returns in the cycle after the filter takes the word (`flt_valid` and `flt_ready` both high).
- R2: A write that arrives while the slot is full, and in the same cycle the filter does not take the word, is ignored. `flt_data` keeps the held word.
- R3: When the filter takes the held word in the same cycle as a write, the new word is loaded and the slot stays full.
- R4: In monitor mode (`mode_dbg`=1), each hand-off to the filter sets the pending request and copies the handed word to `mon_data` on the next cycle.
- R5: If the request is still pending when a hand-off occurs, `ovr` is set. This includes the case where a clear arrives only in that same cycle.
- R6: In monitor mode, a hand-off in the same cycle as `clr_req` or a DMA read acknowledge leaves the request pending.
- R7: `ovr` stays set until `clr_ovr` is written as one. `clr_req` does not clear it.
- R8: With `dma_sel`=0 the request drives `irq` only when `irq_en`=1, and `dma_req` stays low. With `dma_sel`=1 the request drives `dma_req` and `irq` stays low.
- R9: Without a hand-off, `clr_req`=1 clears a pending monitor request. With `dma_sel`=1, `mon_rd`=1 also clears it. `clr_req` has no effect on the standalone request.
- R10: `soft_rst` empties the slot and clears the pending request, `ovr` and `mon_data` in one cycle. It outranks a write in the same cycle.
- R11: Synchronous `rst` leaves the slot empty, with no pending request, `ovr`=0 and `mon_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dbg | input | 1 | 0 = standalone, 1 = monitor |
| dma_sel | input | 1 | 0 = interrupt routing, 1 = DMA routing |
| irq_en | input | 1 | Interrupt enable |
| soft_rst | input | 1 | Single-cycle soft reset command |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | DATA_W | Sample written into the slot |
| flt_ready | input | 1 | Filter accepts the held word |
| flt_valid | output | 1 | Slot holds a word for the filter |
| flt_data | output | DATA_W | Word offered to the filter |
| mon_data | output | DATA_W | Copy of the last word handed off in monitor mode |
| mon_rd | input | 1 | DMA read acknowledge of `mon_data` |
| clr_req | input | 1 | Write-one clear of the pending request |
| clr_ovr | input | 1 | Write-one clear of the overrun flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| ovr | output | 1 | Sticky overrun flag |

## Verification
In monitor mode, a hand-off to the filter can fall in the same cycle as a removal of the pending request. That removal is either a `clr_req` write or a DMA read acknowledge. The bench provokes this collision in both routings by raising `flt_ready` together with the clear while a request is already pending. It then judges the result on the next cycle: the request must still be asserted, `ovr` must be set, and `mon_data` must hold the newly handed word. The bench also collides a write with a take, and a write with a soft reset, and checks which one wins.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef enum logic {
        MODE_STANDALONE = 1'b0,
        MODE_MONITOR    = 1'b1
    } ibuf_mode_e;

    typedef struct packed {
        logic irq;
        logic dma;
    } ibuf_route_t;

    function automatic ibuf_route_t route_req(input logic req,
                                              input logic use_dma,
                                              input logic int_en);
        ibuf_route_t r;
        r.irq = req & ~use_dma & int_en;
        r.dma = req & use_dma;
        return r;
    endfunction

endpackage

// File: rtl/ibuf_slot.sv
module ibuf_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flt_ready,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              take
);
    logic load;

    assign take = full & flt_ready;
    assign load = wr_valid & (~full | take);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (load) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_hold_when_full_R2: assert property (@(posedge clk) disable iff (rst)
        (full && !flt_ready && !soft_rst) |=> (full && $stable(data)));

    assert_soft_empty_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !full);

endmodule

// File: rtl/ibuf_mon.sv
module ibuf_mon #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              mode_dbg,
    input  logic              take,
    input  logic [DATA_W-1:0] take_data,
    input  logic              clr_req,
    input  logic              rd_ack,
    input  logic              clr_ovr,
    output logic              pend,
    output logic              ovr,
    output logic [DATA_W-1:0] mon_data
);
    import ibuf_pkg::*;

    logic handoff;
    assign handoff = (ibuf_mode_e'(mode_dbg) == MODE_MONITOR) & take;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            pend     <= 1'b0;
            ovr      <= 1'b0;
            mon_data <= '0;
        end else begin
            if (ibuf_mode_e'(mode_dbg) != MODE_MONITOR)
                pend <= 1'b0;
            else if (handoff)
                pend <= 1'b1;
            else if (clr_req || rd_ack)
                pend <= 1'b0;

            if (handoff && pend)
                ovr <= 1'b1;
            else if (clr_ovr)
                ovr <= 1'b0;

            if (handoff)
                mon_data <= take_data;
        end
    end

    assert_ovr_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_dbg && take && pend && !soft_rst) |=> ovr);

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_dbg && take && !soft_rst) |=> pend);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr && !clr_ovr && !soft_rst) |=> ovr);

endmodule

// File: rtl/ibuf_route.sv
module ibuf_route (
    input  logic mode_dbg,
    input  logic dma_sel,
    input  logic irq_en,
    input  logic slot_full,
    input  logic pend,
    output logic irq,
    output logic dma_req
);
    import ibuf_pkg::*;

    logic        req;
    ibuf_route_t r;

    always_comb begin
        req     = (ibuf_mode_e'(mode_dbg) == MODE_MONITOR) ? pend : ~slot_full;
        r       = route_req(req, dma_sel, irq_en);
        irq     = r.irq;
        dma_req = r.dma;
    end

    always_comb begin
        assert_one_target_R8: assert (!(irq && dma_req));
    end

endmodule

// File: rtl/ibuf_req_monitor.sv
module ibuf_req_monitor #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_dbg,
    input  logic              dma_sel,
    input  logic              irq_en,
    input  logic              soft_rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flt_ready,
    output logic              flt_valid,
    output logic [DATA_W-1:0] flt_data,
    output logic [DATA_W-1:0] mon_data,
    input  logic              mon_rd,
    input  logic              clr_req,
    input  logic              clr_ovr,
    output logic              irq,
    output logic              dma_req,
    output logic              ovr
);
    logic slot_full;
    logic take;
    logic pend;

    ibuf_slot #(.DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .flt_ready (flt_ready),
        .full      (slot_full),
        .data      (flt_data),
        .take      (take)
    );

    ibuf_mon #(.DATA_W(DATA_W)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .mode_dbg  (mode_dbg),
        .take      (take),
        .take_data (flt_data),
        .clr_req   (clr_req),
        .rd_ack    (mon_rd & dma_sel),
        .clr_ovr   (clr_ovr),
        .pend      (pend),
        .ovr       (ovr),
        .mon_data  (mon_data)
    );

    ibuf_route u_route (
        .mode_dbg  (mode_dbg),
        .dma_sel   (dma_sel),
        .irq_en    (irq_en),
        .slot_full (slot_full),
        .pend      (pend),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    assign flt_valid = slot_full;

    assert_reset_clean_R11: assert property (@(posedge clk)
        rst |=> (!flt_valid && !ovr && mon_data == '0));

    assert_write_fills_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !flt_valid && !soft_rst) |=> flt_valid);

endmodule

// File: tb/ibuf_req_monitor_tb_top.sv
module ibuf_req_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic       mode, sel, ien, wv;
        logic [7:0] wd;
        logic       rdy, crq, cov, mrd, srst;
        logic       e_full, e_irq, e_dma, e_ovr;
        logic [7:0] e_data, e_mon;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        // standalone, interrupt routing: R1 R2 R8
        '{1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,1'b1,1'b1,8'hA5,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'hA5,8'h00},
        '{1'b0,1'b0,1'b1,1'b1,8'h3C,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'hA5,8'h00},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00},
        // standalone, DMA routing: R8
        '{1'b0,1'b1,1'b1,1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h11,8'h00},
        '{1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        // monitor, interrupt routing: R4 R9 R5 R6 R7
        '{1'b1,1'b0,1'b1,1'b1,8'h22,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h22,8'h00},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h22},
        '{1'b1,1'b0,1'b1,1'b1,8'h33,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,8'h33,8'h22},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h33,8'h22},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h33},
        '{1'b1,1'b0,1'b1,1'b1,8'h44,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,8'h44,8'h33},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1,8'h00,8'h44},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,8'h00,8'h44},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h44},
        // monitor, DMA routing: R4 R9 R6 R5
        '{1'b1,1'b1,1'b1,1'b1,8'h55,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h55,8'h44},
        '{1'b1,1'b1,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,8'h00,8'h55},
        '{1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h55},
        '{1'b1,1'b1,1'b1,1'b1,8'h66,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h66,8'h55},
        '{1'b1,1'b1,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,8'h00,8'h66},
        '{1'b1,1'b1,1'b1,1'b1,8'h77,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,8'h77,8'h66},
        '{1'b1,1'b1,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1,8'h00,8'h77},
        // soft reset: R10
        '{1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        // streaming take plus write: R3
        '{1'b0,1'b0,1'b1,1'b1,8'h88,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h88,8'h00},
        '{1'b0,1'b0,1'b1,1'b1,8'h99,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h99,8'h00},
        // soft reset outranks write: R10
        '{1'b0,1'b0,1'b1,1'b1,8'hAA,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00},
        // clr_req ignored in standalone: R9
        '{1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_dbg = 1'b0, dma_sel = 1'b0, irq_en = 1'b1, soft_rst = 1'b0;
    logic wr_valid = 1'b0, flt_ready = 1'b0, mon_rd = 1'b0, clr_req = 1'b0, clr_ovr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic flt_valid, irq, dma_req, ovr;
    logic [W-1:0] flt_data, mon_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibuf_req_monitor #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .mode_dbg(mode_dbg), .dma_sel(dma_sel),
        .irq_en(irq_en), .soft_rst(soft_rst), .wr_valid(wr_valid),
        .wr_data(wr_data), .flt_ready(flt_ready), .flt_valid(flt_valid),
        .flt_data(flt_data), .mon_data(mon_data), .mon_rd(mon_rd),
        .clr_req(clr_req), .clr_ovr(clr_ovr), .irq(irq), .dma_req(dma_req),
        .ovr(ovr)
    );

    task automatic chk(input string what, input int got, input int exp, input string req);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (2) tick();
        rst = 1'b0;
        // R11: state straight after reset
        chk("flt_valid", flt_valid, 0, "R11");
        chk("ovr", ovr, 0, "R11");
        chk("mon_data", mon_data, 0, "R11");
        chk("irq", irq, 1, "R11");

        for (int i = 0; i < NV; i++) begin
            mode_dbg = VEC[i].mode; dma_sel = VEC[i].sel; irq_en = VEC[i].ien;
            wr_valid = VEC[i].wv;   wr_data = VEC[i].wd;  flt_ready = VEC[i].rdy;
            clr_req = VEC[i].crq;   clr_ovr = VEC[i].cov; mon_rd = VEC[i].mrd;
            soft_rst = VEC[i].srst;
            tick();
            chk($sformatf("v%0d flt_valid", i), flt_valid, VEC[i].e_full, "R1/R3/R10");
            chk($sformatf("v%0d irq", i), irq, VEC[i].e_irq, "R8/R1/R6/R9");
            chk($sformatf("v%0d dma_req", i), dma_req, VEC[i].e_dma, "R8/R6/R9");
            chk($sformatf("v%0d ovr", i), ovr, VEC[i].e_ovr, "R5/R7");
            chk($sformatf("v%0d mon_data", i), mon_data, VEC[i].e_mon, "R4");
            if (VEC[i].e_full)
                chk($sformatf("v%0d flt_data", i), flt_data, VEC[i].e_data, "R2/R3");
        end

        // directed R11: hard reset clears a raised overrun
        wr_valid = 1'b0; flt_ready = 1'b0; clr_req = 1'b0; mon_rd = 1'b0; soft_rst = 1'b0;
        mode_dbg = 1'b1; dma_sel = 1'b0;
        wr_valid = 1'b1; wr_data = 8'h5A; tick();
        wr_valid = 1'b0; flt_ready = 1'b1; tick();
        wr_valid = 1'b1; flt_ready = 1'b0; wr_data = 8'hC3; tick();
        wr_valid = 1'b0; flt_ready = 1'b1; tick();
        flt_ready = 1'b0;
        chk("ovr before rst", ovr, 1, "R5");
        chk("mon_data C3", mon_data, 8'hC3, "R4");
        rst = 1'b1; tick(); rst = 1'b0;
        chk("ovr after rst", ovr, 0, "R11");
        chk("irq after rst", irq, 0, "R11");
        chk("mon_data after rst", mon_data, 0, "R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule